// File: doc/BRIEF.md
# Sixteen-bit flag-producing ALU with three-way compare

This block is a purely combinational arithmetic and logic unit for 16-bit operands. A 4-bit operation selector picks one of ten functions: add, subtract, four bitwise functions, inversion of the first operand, single-bit logical shifts in either direction, and a three-way compare. It always drives a 16-bit result and five status flags: zero, carry/borrow, negative, signed overflow and operand equality.

The compare function encodes how the two operands are ordered. It returns 0x0000 when they are equal, 0x0001 when the first operand is larger, and 0xFFFF when it is smaller. Ordering is by unsigned magnitude. A datapath can therefore branch on the result word alone or on its flags. The equality flag is separate from the compare function and is valid under every operation code. The carry and overflow flags carry meaning only for addition and subtraction and are cleared for all other codes.

The block has no clock and no state. A surrounding pipeline registers its inputs and outputs as it needs.

Top module: `alu16_flagcore`

## Requirements
- R1: Code 0 (add) gives (A + B) mod 2^16, and the carry flag is the carry out of bit 15.
- R2: Code 1 (subtract) gives (A - B) mod 2^16, and the carry flag is set exactly when A < B as unsigned values (borrow).
- R3: For codes 0 and 1, the overflow flag is set exactly when the true signed (two's complement) sum or difference lies outside -32768..32767.
- R4: For every code other than 0 and 1, the carry and overflow flags are 0.
- R5: Codes 2, 3, 4 and 8 give A AND B, A OR B, A XOR B and NOT (A AND B) respectively.
- R6: Code 5 gives the bitwise inverse of A, and B has no effect on any output except the equal flag.
- R7: Code 6 shifts A left by one and code 7 shifts A right by one. Both are logical shifts that fill with 0 and drop the bit shifted out.
- R8: Code 9 (compare) gives 0x0000 if A == B, 0x0001 if A > B and 0xFFFF if A < B, comparing as unsigned values.
- R9: The zero flag is 1 exactly when the 16-bit result is 0x0000.
- R10: The negative flag equals bit 15 of the result.
- R11: The equal flag is 1 exactly when A == B, under every operation code.
- R12: Codes 10 to 15 give a result of 0x0000, so the zero flag is 1 and the negative flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand (A) |
| opnd_b | input | 16 | Second operand (B) |
| op_sel | input | 4 | Operation code |
| result | output | 16 | Result word |
| flag_zero | output | 1 | Result is zero |
| flag_carry | output | 1 | Carry out on add, borrow on subtract |
| flag_neg | output | 1 | Bit 15 of the result |
| flag_ovf | output | 1 | Signed overflow on add or subtract |
| flag_eq | output | 1 | Operands are equal |

## Verification
There are no registers between the ports, so the result and all five flags are due in the same cycle that the operands and code are applied. The bench changes inputs shortly after each rising edge and samples every output at the following falling edge. This leaves half a period for the logic to settle, and no output is read across an edge where it may be changing. The checks combine random operands and codes with directed cases at the sign and magnitude boundaries: 0x7FFF, 0x8000, 0xFFFF and equal operands.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOTA = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_NAND = 4'd8,
    OP_CMP  = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic neg;
    logic ovf;
    logic eq;
  } alu_flags_t;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cy_or_bw,
  output logic         ovf
);
  localparam int MSB = W - 1;

  // Widened adder with a carry-in so that subtraction reuses it.
  function automatic logic [W:0] add_wide(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  // Signed overflow: both addends share a sign and the sum's sign differs from it.
  function automatic logic sign_ovf(input logic sx, input logic sy, input logic ss);
    return (sx == sy) && (ss != sx);
  endfunction

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff    = do_sub ? ~b : b;
    wide     = add_wide(a, b_eff, do_sub);
    sum      = wide[MSB:0];
    // When subtracting, the adder's carry out is the inverse of the borrow.
    cy_or_bw = do_sub ? ~wide[W] : wide[W];
    ovf      = sign_ovf(a[MSB], b_eff[MSB], wide[MSB]);
  end

  // R3: operands of opposite effective sign never overflow.
  always_comb begin
    if (!do_sub && (a[MSB] != b[MSB]))
      p_add_mixed_sign_r3: assert (!ovf) else $error("add overflow with mixed signs");
    if (do_sub && (a[MSB] == b[MSB]))
      p_sub_same_sign_r3: assert (!ovf) else $error("sub overflow with equal signs");
  end

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  localparam int MSB = W - 1;

  logic [W-1:0] v_and, v_or, v_xor, v_nand, v_inv;

  // One slice per bit position.
  for (genvar i = 0; i < W; i++) begin : g_slice
    assign v_and[i]  = a[i] & b[i];
    assign v_or[i]   = a[i] | b[i];
    assign v_xor[i]  = a[i] ^ b[i];
    assign v_nand[i] = ~(a[i] & b[i]);
    assign v_inv[i]  = ~a[i];
  end

  function automatic logic [W-1:0] shl1(input logic [W-1:0] x);
    return {x[MSB-1:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] shr1(input logic [W-1:0] x);
    return {1'b0, x[MSB:1]};
  endfunction

  always_comb begin
    unique case (op)
      OP_AND:  y = v_and;
      OP_OR:   y = v_or;
      OP_XOR:  y = v_xor;
      OP_NAND: y = v_nand;
      OP_NOTA: y = v_inv;
      OP_SHL:  y = shl1(a);
      OP_SHR:  y = shr1(a);
      default: y = '0;
    endcase
  end

  // R7: the vacated bit of each shift is always zero.
  always_comb begin
    if (op == OP_SHL)
      p_shl_fill_r7: assert (!y[0]) else $error("shl lsb not zero");
    if (op == OP_SHR)
      p_shr_fill_r7: assert (!y[MSB]) else $error("shr msb not zero");
  end

endmodule

// File: rtl/alu16_order.sv
module alu16_order #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         gt,
  output logic         lt,
  output logic [W-1:0] ord_word
);

  function automatic logic [W-1:0] encode_order(input logic e, input logic g);
    if (e)      return '0;
    else if (g) return {{(W-1){1'b0}}, 1'b1};
    else        return '1;
  endfunction

  always_comb begin
    eq       = (a == b);
    gt       = (a > b);
    lt       = !eq && !gt;
    ord_word = encode_order(eq, gt);
  end

  // R8: exactly one ordering holds.
  always_comb begin
    p_order_onehot_r8: assert ($onehot({eq, gt, lt})) else $error("ordering not one-hot");
  end

endmodule

// File: rtl/alu16_flagcore.sv
module alu16_flagcore
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result,
  output logic         flag_zero,
  output logic         flag_carry,
  output logic         flag_neg,
  output logic         flag_ovf,
  output logic         flag_eq
);
  localparam int MSB = W - 1;

  alu_op_e      op;
  logic         is_arith;
  logic [W-1:0] as_sum, bw_y, ord_word;
  logic         as_cy, as_ovf;
  logic         ord_eq, ord_gt, ord_lt;
  alu_flags_t   flags;

  assign op       = alu_op_e'(op_sel);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu16_addsub #(.W(W)) u_addsub (
    .a        (opnd_a),
    .b        (opnd_b),
    .do_sub   (op == OP_SUB),
    .sum      (as_sum),
    .cy_or_bw (as_cy),
    .ovf      (as_ovf)
  );

  alu16_bitwise #(.W(W)) u_bitwise (
    .a  (opnd_a),
    .b  (opnd_b),
    .op (op),
    .y  (bw_y)
  );

  alu16_order #(.W(W)) u_order (
    .a        (opnd_a),
    .b        (opnd_b),
    .eq       (ord_eq),
    .gt       (ord_gt),
    .lt       (ord_lt),
    .ord_word (ord_word)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = as_sum;
      OP_CMP:         result = ord_word;
      default:        result = bw_y;
    endcase
    flags.zero  = (result == '0);
    flags.neg   = result[MSB];
    flags.carry = is_arith & as_cy;
    flags.ovf   = is_arith & as_ovf;
    flags.eq    = ord_eq;
  end

  assign flag_zero  = flags.zero;
  assign flag_carry = flags.carry;
  assign flag_neg   = flags.neg;
  assign flag_ovf   = flags.ovf;
  assign flag_eq    = flags.eq;

  // Cross-checks between the separate units.
  always_comb begin
    if (op == OP_ADD && flag_carry)
      p_add_wrap_r1: assert (result < opnd_a) else $error("carry without wrap");
    if (op == OP_SUB)
      p_borrow_lt_r2: assert (flag_carry == ord_lt) else $error("borrow mismatch");
    if (!is_arith)
      p_quiet_flags_r4: assert (!flag_carry && !flag_ovf) else $error("stray carry/ovf");
    if (op == OP_CMP)
      p_cmp_word_r8: assert ((result == '0) || (result == {{(W-1){1'b0}}, 1'b1}) || (&result))
        else $error("compare word illegal");
    if (op == OP_CMP)
      p_cmp_eq_r11: assert (flag_zero == flag_eq) else $error("compare zero vs eq");
    if (op_sel >= 4'd10)
      p_unused_zero_r12: assert (flag_zero && !flag_neg) else $error("unused code output");
  end

endmodule

// File: tb/alu16_flagcore_bench.sv
module alu16_flagcore_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic [15:0] result;
  logic        f_zero, f_carry, f_neg, f_ovf, f_eq;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu16_flagcore u_alu16_flagcore (
    .opnd_a(a), .opnd_b(b), .op_sel(op), .result(result),
    .flag_zero(f_zero), .flag_carry(f_carry), .flag_neg(f_neg),
    .flag_ovf(f_ovf), .flag_eq(f_eq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (op=%0d a=%h b=%h)",
               req, what, act, exp, op, a, b);
    end
  endtask

  function automatic string res_req(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd8: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd9: return "R8";
      default: return "R12";
    endcase
  endfunction

  // Reference model written from the requirements with integer arithmetic.
  task automatic model(input logic [15:0] x, input logic [15:0] y, input logic [3:0] o,
                       output logic [15:0] r, output bit c, output bit v);
    int ux = int'(x), uy = int'(y);
    int sx = int'($signed(x)), sy = int'($signed(y));
    int t;
    c = 0; v = 0;
    case (o)
      4'd0: begin t = ux + uy; r = t[15:0]; c = (t > 65535);
                  v = (sx + sy > 32767) || (sx + sy < -32768); end
      4'd1: begin t = ux - uy; r = t[15:0]; c = (ux < uy);
                  v = (sx - sy > 32767) || (sx - sy < -32768); end
      4'd2: r = x & y;
      4'd3: r = x | y;
      4'd4: r = x ^ y;
      4'd5: r = ~x;
      4'd6: begin t = ux * 2; r = t[15:0]; end
      4'd7: begin t = ux / 2; r = t[15:0]; end
      4'd8: r = ~(x & y);
      4'd9: r = (ux == uy) ? 16'h0000 : (ux > uy) ? 16'h0001 : 16'hFFFF;
      default: r = 16'h0000;
    endcase
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [3:0] o);
    logic [15:0] er;
    bit ec, ev;
    @(posedge clk);
    #1;
    a = x; b = y; op = o;
    @(negedge clk);  // combinational: due in the same cycle
    model(x, y, o, er, ec, ev);
    chk(res_req(o), "result", int'(result), int'(er));
    chk("R9", "zero", int'(f_zero), int'(er == 16'h0));
    chk("R10", "neg", int'(f_neg), int'(er[15]));
    chk("R11", "eq", int'(f_eq), int'(x == y));
    chk((o == 4'd0) ? "R1" : (o == 4'd1) ? "R2" : "R4", "carry", int'(f_carry), int'(ec));
    chk((o <= 4'd1) ? "R3" : "R4", "ovf", int'(f_ovf), int'(ev));
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(0, 7))
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'h0001;
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] keep;
    int unused_seed;
    unused_seed = $urandom(32'd7741);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs select ADD of zeros.
    @(negedge clk);
    chk("R9", "reset zero", int'(f_zero), 1);
    chk("R1", "reset result", int'(result), 0);
    // R1 / R3 directed: carry out and signed overflow boundaries.
    apply(16'hFFFF, 16'h0001, 4'd0);
    apply(16'h7FFF, 16'h0001, 4'd0);
    apply(16'h8000, 16'h8000, 4'd0);
    // R2 / R3 directed: borrow and subtract overflow.
    apply(16'h0000, 16'h0001, 4'd1);
    apply(16'h8000, 16'h0001, 4'd1);
    apply(16'h1234, 16'h1234, 4'd1);
    // R8 compare: equal, greater, less, unsigned with high bit.
    apply(16'h5555, 16'h5555, 4'd9);
    apply(16'h8000, 16'h7FFF, 4'd9);
    apply(16'h0001, 16'hFFFF, 4'd9);
    // R7 shifts dropping the outgoing bit.
    apply(16'h8001, 16'h0000, 4'd6);
    apply(16'h8001, 16'h0000, 4'd7);
    // R6: B has no effect on NOT A.
    apply(16'h0F0F, 16'h0000, 4'd5);
    keep = result;
    apply(16'h0F0F, 16'hABCD, 4'd5);
    chk("R6", "nota ignores b", int'(result), int'(keep));
    // R12 unused codes, R5 logic functions.
    for (int o = 10; o < 16; o++) apply(16'hFFFF, 16'hFFFF, 4'(o));
    for (int o = 2; o < 9; o++) apply(16'hC3A5, 16'h0FF0, 4'(o));
    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] x;
      x = pick();
      apply(x, ($urandom_range(0, 5) == 0) ? x : pick(), 4'($urandom_range(0, 15)));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule